// File: doc/BRIEF.md
# Lockable Input Crossbar Select Bank

This block holds the routing choices of a sixteen-channel input crossbar. Every channel owns a select register holding an input index k, and the channel output line follows input line k of a shared N-bit input vector. Software programs the routing through a simple word-addressed register port: an address, write data, a write strobe and combinational read data.

Two guards stand in front of every write. A global protection-enable input must be high for any register write to land, the lock register included. Each channel also has its own lock bit, which software can only set. Once set, that channel's routing is frozen until the next system reset. Reads are never gated. Each cycle the address is classified into one of three access kinds: ACC_NONE for an unmapped offset, ACC_SEL for a select register and ACC_LOCK for the lock register. That kind steers both the write enables and the read-data multiplexer. The block holds no sequencing state beyond the registers themselves.

Top module: `xsel_bank`

## Requirements
- R1: After reset every select register and every lock bit is 0, so every read returns 0 and every channel output follows input line 0.
- R2: With write strobe and protection enable high, a write to offset c (0 to 15) stores wdata[15:0] into the select register of channel c. Reading that offset returns the value in bits 15:0 and 0 in bits 31:16.
- R3: Each channel output equals input line k, where k is the channel's current select value. The output follows input changes combinationally, and a select write shows on the output right after the clock edge that takes the write.
- R4: A channel whose select value is N or more drives its output to 0. N is 32 by default, so value 31 is still routed.
- R5: The lock register sits at offset 0x1E. Writing 1 to bit i sets the lock of channel i (select offset i). Writing 0 leaves a bit unchanged, and no write clears a set bit. Bits 31:16 read as 0 and ignore writes.
- R6: A write to the select register of a locked channel is ignored, and writes to unlocked channels still work.
- R7: While protection enable is low, writes to select registers and to the lock register have no effect.
- R8: Offsets other than 0x00 to 0x0F and 0x1E read as 0, and writes to them change no register.
- R9: Select registers and the lock register read back their values whether or not the channel is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| addr | input | 5 | Word offset of the register access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| prot_en | input | 1 | Global write-protection enable, writes land only while high |
| rdata | output | 32 | Combinational read data for addr |
| in_vec | input | 32 | Shared input lines |
| ch_out | output | 16 | Routed channel outputs, bit c for channel c |

## Verification
A select write and a change of the input vector can fall in the same cycle. The bench provokes this on purpose by driving a fresh input pattern in every cycle it issues a write. Before the edge, the output is judged against the old select applied to the new inputs. After the edge, it is judged against the new select. A behavioural model built from integer arrays predicts both values and is compared against rdata and ch_out on every clock, through lock setting, protection-off writes and unmapped accesses.

// File: rtl/xsel_pkg.sv
package xsel_pkg;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SEL  = 2'd1,
        ACC_LOCK = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/xsel_decode.sv
module xsel_decode
    import xsel_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int N_CH        = 16,
    parameter int LOCK_OFFSET = 30,
    localparam int IDX_W      = $clog2(N_CH)
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);

    always_comb begin
        idx  = addr[IDX_W-1:0];
        kind = ACC_NONE;
        if (addr < ADDR_W'(N_CH)) begin
            kind = ACC_SEL;
        end else if (addr == ADDR_W'(LOCK_OFFSET)) begin
            kind = ACC_LOCK;
        end
    end

endmodule

// File: rtl/xsel_regfile.sv
module xsel_regfile
    import xsel_pkg::*;
#(
    parameter int N_CH   = 16,
    parameter int SEL_W  = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(N_CH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  acc_kind_e                  kind,
    input  logic [IDX_W-1:0]           idx,
    input  logic                       wr_en,
    input  logic                       prot_en,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic [N_CH-1:0][SEL_W-1:0] sel_q,
    output logic [N_CH-1:0]            lock_q
);

    logic             wr_ok;
    logic [N_CH-1:0]  ch_we;
    logic             lock_we;
    logic             unused_wdata_hi;

    assign wr_ok           = wr_en && prot_en;
    assign lock_we         = wr_ok && (kind == ACC_LOCK);
    assign unused_wdata_hi = ^wdata[DATA_W-1:SEL_W];

    for (genvar c = 0; c < N_CH; c++) begin : g_we
        assign ch_we[c] = wr_ok && (kind == ACC_SEL) &&
                          (idx == IDX_W'(c)) && !lock_q[c];

        // R6: a locked channel keeps its select value
        assert_locked_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            lock_q[c] |=> $stable(sel_q[c]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            for (int c = 0; c < N_CH; c++) begin
                if (ch_we[c]) begin
                    sel_q[c] <= wdata[SEL_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else if (lock_we) begin
            lock_q <= lock_q | wdata[N_CH-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        unique case (kind)
            ACC_SEL:  rdata[SEL_W-1:0] = sel_q[idx];
            ACC_LOCK: rdata[N_CH-1:0]  = lock_q;
            ACC_NONE: rdata = '0;
            default:  rdata = '0;
        endcase
    end

    // R5: lock bits never fall once set
    assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((lock_q & $past(lock_q)) == $past(lock_q)));

    // R7: protection off freezes the whole bank
    assert_noprot_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_en |=> ($stable(sel_q) && $stable(lock_q)));

    // R8: unmapped writes touch nothing
    assert_unmapped_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (kind == ACC_NONE)) |=> ($stable(sel_q) && $stable(lock_q)));

endmodule

// File: rtl/xsel_mux.sv
module xsel_mux #(
    parameter int N_INPUTS = 32,
    parameter int SEL_W    = 16,
    localparam int IN_IDX_W = (N_INPUTS > 1) ? $clog2(N_INPUTS) : 1
) (
    input  logic [N_INPUTS-1:0] in_vec,
    input  logic [SEL_W-1:0]    sel,
    output logic                y
);

    logic in_range;

    assign in_range = (sel < SEL_W'(N_INPUTS));

    always_comb begin
        y = 1'b0;
        if (in_range) begin
            y = in_vec[sel[IN_IDX_W-1:0]];
        end
    end

endmodule

// File: rtl/xsel_bank.sv
module xsel_bank
    import xsel_pkg::*;
#(
    parameter int N_INPUTS    = 32,
    parameter int N_CH        = 16,
    parameter int SEL_W       = 16,
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 32,
    parameter int LOCK_OFFSET = 30,
    localparam int IDX_W      = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              prot_en,
    output logic [DATA_W-1:0] rdata,
    input  logic [N_INPUTS-1:0] in_vec,
    output logic [N_CH-1:0]   ch_out
);

    acc_kind_e                  kind;
    logic [IDX_W-1:0]           idx;
    logic [N_CH-1:0][SEL_W-1:0] sel_q;
    logic [N_CH-1:0]            lock_q;

    xsel_decode #(
        .ADDR_W      (ADDR_W),
        .N_CH        (N_CH),
        .LOCK_OFFSET (LOCK_OFFSET)
    ) u_decode (
        .addr (addr),
        .kind (kind),
        .idx  (idx)
    );

    xsel_regfile #(
        .N_CH   (N_CH),
        .SEL_W  (SEL_W),
        .DATA_W (DATA_W)
    ) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (kind),
        .idx     (idx),
        .wr_en   (wr_en),
        .prot_en (prot_en),
        .wdata   (wdata),
        .rdata   (rdata),
        .sel_q   (sel_q),
        .lock_q  (lock_q)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        xsel_mux #(
            .N_INPUTS (N_INPUTS),
            .SEL_W    (SEL_W)
        ) u_mux (
            .in_vec (in_vec),
            .sel    (sel_q[c]),
            .y      (ch_out[c])
        );

        // R4: out-of-range select parks the channel low
        assert_range_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_q[c] >= SEL_W'(N_INPUTS)) |-> !ch_out[c]);
    end

endmodule

// File: tb/xsel_bank_bench.sv
module xsel_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        prot_en = 1'b0;
    logic [31:0] rdata;
    logic [31:0] in_vec = '0;
    logic [15:0] ch_out;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    logic [15:0] m_sel [16];
    logic [15:0] m_lock;

    always #10 clk = ~clk;

    xsel_bank u_xsel_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wdata   (wdata),
        .wr_en   (wr_en),
        .prot_en (prot_en),
        .rdata   (rdata),
        .in_vec  (in_vec),
        .ch_out  (ch_out)
    );

    function automatic logic [31:0] exp_rdata(input logic [4:0] a);
        if (a < 5'd16) return {16'h0, m_sel[a[3:0]]};
        if (a == 5'd30) return {16'h0, m_lock};
        return 32'h0;
    endfunction

    function automatic logic [15:0] exp_out(input logic [31:0] iv);
        logic [15:0] r;
        for (int c = 0; c < 16; c++) begin
            r[c] = (m_sel[c] < 16'd32) ? iv[m_sel[c][4:0]] : 1'b0;
        end
        return r;
    endfunction

    task automatic compare();
        logic [31:0] er;
        logic [15:0] eo;
        er = exp_rdata(addr);
        eo = exp_out(in_vec);
        checks++;
        if (rdata !== er) begin
            errors++;
            $display("FAIL %s rdata addr %0h actual %h expected %h", phase, addr, rdata, er);
        end
        checks++;
        if (ch_out !== eo) begin
            errors++;
            $display("FAIL %s ch_out actual %h expected %h", phase, ch_out, eo);
        end
    endtask

    task automatic cyc(input logic [4:0] a, input logic [31:0] d,
                       input logic w, input logic p, input logic [31:0] iv);
        @(negedge clk);
        addr = a; wdata = d; wr_en = w; prot_en = p; in_vec = iv;
        #2;
        compare();
        @(posedge clk);
        if (w && p) begin
            if (a < 5'd16) begin
                if (!m_lock[a[3:0]]) m_sel[a[3:0]] = d[15:0];
            end else if (a == 5'd30) begin
                m_lock = m_lock | d[15:0];
            end
        end
    endtask

    function automatic logic [31:0] pat(input int k);
        return 32'hA5C3_0F96 ^ (32'(k) * 32'h9E37_79B9);
    endfunction

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int k;
        k = 0;
        for (int c = 0; c < 16; c++) m_sel[c] = '0;
        m_lock = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        phase = "R1";
        for (int a = 0; a < 32; a++) begin
            cyc(5'(a), 32'h0, 1'b0, 1'b1, pat(k++));
        end

        // R2: write and read back a select
        phase = "R2";
        cyc(5'd0, 32'hABCD_0005, 1'b1, 1'b1, pat(k++));
        cyc(5'd0, 32'h0, 1'b0, 1'b1, pat(k++));

        // R3: routing, writes coincide with input changes
        phase = "R3";
        for (int c = 0; c < 16; c++) begin
            cyc(5'(c), 32'((c * 7 + 3) % 32), 1'b1, 1'b1, pat(k++));
            cyc(5'(c), 32'h0, 1'b0, 1'b1, pat(k++));
        end
        for (int j = 0; j < 20; j++) begin
            cyc(5'(j % 16), 32'h0, 1'b0, 1'b0, pat(k++));
        end

        // R4: out-of-range and top valid select
        phase = "R4";
        cyc(5'd3, 32'd32, 1'b1, 1'b1, 32'hFFFF_FFFF);
        cyc(5'd4, 32'h0000_FFFF, 1'b1, 1'b1, 32'hFFFF_FFFF);
        cyc(5'd5, 32'd31, 1'b1, 1'b1, 32'hFFFF_FFFF);
        cyc(5'd3, 32'h0, 1'b0, 1'b1, 32'hFFFF_FFFF);
        cyc(5'd5, 32'h0, 1'b0, 1'b1, 32'h8000_0000);

        // R7: protection off
        phase = "R7";
        cyc(5'd6, 32'd1, 1'b1, 1'b0, pat(k++));
        cyc(5'd30, 32'h0000_FFFF, 1'b1, 1'b0, pat(k++));
        cyc(5'd6, 32'h0, 1'b0, 1'b0, pat(k++));
        cyc(5'd30, 32'h0, 1'b0, 1'b0, pat(k++));

        // R5: lock set-only, reserved bits
        phase = "R5";
        cyc(5'd30, 32'h0000_0005, 1'b1, 1'b1, pat(k++));
        cyc(5'd30, 32'h0, 1'b0, 1'b1, pat(k++));
        cyc(5'd30, 32'h0000_0000, 1'b1, 1'b1, pat(k++));
        cyc(5'd30, 32'hFFFF_0000, 1'b1, 1'b1, pat(k++));
        cyc(5'd30, 32'h0, 1'b0, 1'b1, pat(k++));

        // R6: locked channels ignore writes, neighbour still writable
        phase = "R6";
        cyc(5'd0, 32'd9, 1'b1, 1'b1, pat(k++));
        cyc(5'd2, 32'd9, 1'b1, 1'b1, pat(k++));
        cyc(5'd1, 32'd9, 1'b1, 1'b1, pat(k++));

        // R9: reads of locked and unlocked registers
        phase = "R9";
        cyc(5'd0, 32'h0, 1'b0, 1'b1, pat(k++));
        cyc(5'd1, 32'h0, 1'b0, 1'b1, pat(k++));
        cyc(5'd2, 32'h0, 1'b0, 1'b1, pat(k++));

        // R8: unmapped offsets
        phase = "R8";
        cyc(5'd16, 32'hFFFF_FFFF, 1'b1, 1'b1, pat(k++));
        cyc(5'd29, 32'hFFFF_FFFF, 1'b1, 1'b1, pat(k++));
        cyc(5'd31, 32'hFFFF_FFFF, 1'b1, 1'b1, pat(k++));
        for (int a = 0; a < 32; a++) begin
            cyc(5'(a), 32'h0, 1'b0, 1'b1, pat(k++));
        end

        // R6: lock everything, then try every channel
        phase = "R6";
        cyc(5'd30, 32'h0000_FFFF, 1'b1, 1'b1, pat(k++));
        for (int c = 0; c < 16; c++) begin
            cyc(5'(c), 32'd17, 1'b1, 1'b1, pat(k++));
        end
        phase = "R9";
        for (int c = 0; c < 16; c++) begin
            cyc(5'(c), 32'h0, 1'b0, 1'b1, pat(k++));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule